// File: doc/BRIEF.md
# Inverted Wrap-Carry Adder

This block adds two N-bit operands. The carry that enters bit 0 is the complement of the carry that leaves the top bit. A plain adder that fed its inverted carry-out back into its carry-in would form a combinational loop. This block instead solves the circular carry equations directly, so the result is stable for every operand pair, including the pair whose sum is exactly all ones. The block forms the core of a modulo 2^N+1 adder for diminished-one operands. The surrounding logic that handles zero operands stays outside.

The carry logic is sparse. Only K "anchor" carries are formed by full circular group evaluation. Each anchor combines the group below it with the inverted generate of the group that wraps around above it. All other carries come from one late operator stage. That stage combines the local group generate/propagate of a short segment with the anchor directly beneath it. The lowest segment uses the inverted full-width generate instead. The parameter K sets the trade between the number of operators and fan-out:

- K = 1 gives a plain prefix adder with a late increment level.
- K = N gives a fully circular network with no late stage.

An optional register stage on the operands and results can be selected for timing studies. It uses a synchronous, active-low reset.

Top module: `inv_wrap_adder`

## Requirements
- R1: `sum_o` equals (A + B + W) mod 2^N, where W is the value presented on `wrap_o` for the same operands.
- R2: `wrap_o` is 1 exactly when A + B < 2^N, i.e. when the N-bit addition produces no carry out; otherwise it is 0.
- R3: When A + B = 2^N − 1 (every bit propagates and none generates), `sum_o` is all zeros and `wrap_o` is 1.
- R4: When A and B are both all ones, `sum_o` is 2^N − 2 and `wrap_o` is 0.
- R5: When A and B are both zero, `sum_o` is 1 and `wrap_o` is 1.
- R6: When A + B = 2^N exactly, `sum_o` is all zeros and `wrap_o` is 0.
- R7: For a given width, the outputs are identical for every legal anchor count K (1, N/4, N/2 and N).
- R8: With REG_IO = 1, the result for operands sampled at one rising edge appears at the outputs after the next rising edge. One new result is accepted every cycle. A low `rst_n` at a rising edge clears both outputs to 0. With REG_IO = 0, the outputs follow the inputs without a clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional register stage and the embedded checks |
| rst_n | input | 1 | Synchronous active-low reset |
| a_i | input | N | First operand |
| b_i | input | N | Second operand |
| sum_o | output | N | Sum with the inverted wrap carry folded in |
| wrap_o | output | 1 | Carry fed into bit 0, equal to the complement of the carry out |

## Verification
The hardest corner is an operand pair that propagates on every bit with no generate anywhere. A design that gets the wrap wrong here returns all ones, or a result that depends on K, instead of zero with the wrap set. That pair is kept apart from a sum of exactly 2^N, which must give zero with the wrap clear. A mixed-up seed would swap those two cases. The all-ones and all-zeros pairs catch a late stage that is seeded from the wrong anchor or from an uninverted carry. Comparing four anchor counts on the same 16-bit vectors shows up a segment boundary that is off by one.

// File: rtl/iwa_pkg.sv
// Shared types and carry helpers for the inverted wrap-carry adder.
// Assumes operand widths never exceed MAXW bits.
package iwa_pkg;

    localparam int MAXW = 32;

    // Generate/propagate pair of a bit or a group of bits.
    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    // Prefix operator: hi group absorbs the lower group lo.
    function automatic gp_t gp_merge(input gp_t hi, input gp_t lo);
        gp_t r;
        r.g = hi.g | (hi.p & lo.g);
        r.p = hi.p & lo.p;
        return r;
    endfunction

    // Carry out of bit hi given the group hi..lo and an incoming carry.
    // Bits outside the span act as identity (g=0, p=1); the fold is a
    // log-depth doubling network over the masked pairs.
    function automatic logic span_carry(input logic [MAXW-1:0] gv,
                                        input logic [MAXW-1:0] pv,
                                        input int hi, input int lo,
                                        input logic cin);
        logic [MAXW-1:0] tg;
        logic [MAXW-1:0] tp;
        for (int i = 0; i < MAXW; i++) begin
            if (i >= lo && i <= hi) begin
                tg[i] = gv[i];
                tp[i] = pv[i];
            end else begin
                tg[i] = 1'b0;
                tp[i] = 1'b1;
            end
        end
        for (int d = 1; d < MAXW; d = d * 2) begin
            for (int i = MAXW - 1; i >= d; i--) begin
                gp_t r;
                r = gp_merge('{g: tg[i], p: tp[i]}, '{g: tg[i-d], p: tp[i-d]});
                tg[i] = r.g;
                tp[i] = r.p;
            end
        end
        return tg[hi] | (tp[hi] & cin);
    endfunction

endpackage

// File: rtl/iwa_bitgen.sv
// Per-bit precompute: generate, propagate and half-sum of each bit pair.
// Purely combinational; no assumptions beyond matching operand widths.
module iwa_bitgen #(
    parameter int N = 16
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    output logic [N-1:0] g_o,
    output logic [N-1:0] p_o,
    output logic [N-1:0] h_o
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        // one AND, OR and XOR per bit position
        assign g_o[i] = a_i[i] & b_i[i];
        assign p_o[i] = a_i[i] | b_i[i];
        assign h_o[i] = a_i[i] ^ b_i[i];
    end

endmodule

// File: rtl/iwa_anchor.sv
// Anchor carries: the circular carry out of bit m*S+S-1 for each of the
// K segments (S = N/K). A lower anchor merges its prefix group with the
// inverted generate of the wrapped group above it; the top anchor is the
// plain full-width group generate (the true carry out).
// Assumes N and K are powers of two with 1 <= K <= N <= MAXW.
module iwa_anchor
    import iwa_pkg::*;
#(
    parameter int N = 16,
    parameter int K = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] g_i,
    input  logic [N-1:0] p_i,
    output logic [K-1:0] anc_o
);

    localparam int S = N / K;

    for (genvar m = 0; m < K; m++) begin : g_anc
        localparam int J = m * S + S - 1;
        if (m == K - 1) begin : g_top
            // full-width group generate = carry out of the top bit
            assign anc_o[m] = span_carry(MAXW'(g_i), MAXW'(p_i), N - 1, 0, 1'b0);
        end else begin : g_low
            // prefix group J..0 merged with inverted wrapped group N-1..J+1
            assign anc_o[m] = span_carry(MAXW'(g_i), MAXW'(p_i), J, 0,
                              ~span_carry(MAXW'(g_i), MAXW'(p_i), N - 1, J + 1, 1'b0));

            // a generating bit forces its anchor carry high
            p_anchor_gen_r2: assert property (@(posedge clk) disable iff (!rst_n)
                g_i[J] |-> anc_o[m])
                else $error("anchor %0d not set by generate", J);

            // a killing bit forces its anchor carry low
            p_anchor_kill_r2: assert property (@(posedge clk) disable iff (!rst_n)
                !p_i[J] |-> !anc_o[m])
                else $error("anchor %0d not cleared by kill", J);
        end
    end

endmodule

// File: rtl/iwa_fill.sv
// Late stage: derives each non-anchor carry from the local group of its
// segment and the carry beneath the segment (the anchor below, or for the
// lowest segment the inverted carry out), then forms the sum bits.
// Assumes anc_i[K-1] is the true carry out of the top bit.
module iwa_fill
    import iwa_pkg::*;
#(
    parameter int N = 16,
    parameter int K = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] g_i,
    input  logic [N-1:0] p_i,
    input  logic [N-1:0] h_i,
    input  logic [K-1:0] anc_i,
    output logic [N-1:0] sum_o,
    output logic         wrap_o
);

    localparam int S = N / K;

    logic [N-1:0] c_out;
    logic         seed;

    // carry entering bit 0 is the inverted carry out
    assign seed = ~anc_i[K-1];

    for (genvar m = 0; m < K; m++) begin : g_seg
        localparam int BASE = m * S;
        if (S == 1) begin : g_direct
            // every bit is an anchor
            assign c_out[BASE] = anc_i[m];
        end else begin : g_late
            logic cprev;
            if (m == 0) begin : g_first
                assign cprev = seed;
            end else begin : g_next
                assign cprev = anc_i[m-1];
            end
            for (genvar t = 0; t < S; t++) begin : g_bit
                if (t == S - 1) begin : g_anchor
                    assign c_out[BASE+t] = anc_i[m];
                end else begin : g_derived
                    // one operator: local group BASE+t..BASE with carry beneath
                    assign c_out[BASE+t] = span_carry(MAXW'(g_i), MAXW'(p_i),
                                                      BASE + t, BASE, cprev);
                end
            end

            // a fully propagating, non-generating stretch passes the seed through
            p_fill_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
                ((&p_i[BASE+S-2:BASE]) && !(|g_i[BASE+S-2:BASE]))
                |-> (c_out[BASE+S-2:BASE] == {(S-1){cprev}}))
                else $error("segment %0d failed to pass its seed", m);
        end
    end

    // sum bit i takes the carry out of bit i-1; bit 0 takes the seed
    assign sum_o  = h_i ^ {c_out[N-2:0], seed};
    assign wrap_o = seed;

endmodule

// File: rtl/inv_wrap_adder.sv
// Top level of the inverted wrap-carry adder. Precompute, anchor network
// and late fill stage, with an optional operand/result register stage
// (REG_IO=1) under a synchronous active-low reset.
// Assumes N in {4,8,16,32} and K a power of two in 1..N; other values stop
// elaboration.
module inv_wrap_adder #(
    parameter int N      = 16,
    parameter int K      = 8,
    parameter int REG_IO = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    output logic [N-1:0] sum_o,
    output logic         wrap_o
);

    if (!(N == 4 || N == 8 || N == 16 || N == 32) || K < 1 || K > N ||
        ((K & (K - 1)) != 0)) begin : g_bad_cfg
        $error("inv_wrap_adder: unsupported N=%0d K=%0d", N, K);
    end

    logic [N-1:0] op_a, op_b;
    logic [N-1:0] g_w, p_w, h_w;
    logic [K-1:0] anc_w;
    logic [N-1:0] core_sum;
    logic         core_cin;
    logic [N:0]   ext_sum;

    if (REG_IO != 0) begin : g_reg
        logic [N-1:0] a_q, b_q, s_q;
        logic         w_q;

        // capture operands
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                a_q <= '0;
                b_q <= '0;
            end else begin
                a_q <= a_i;
                b_q <= b_i;
            end
        end

        // capture results
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s_q <= '0;
                w_q <= 1'b0;
            end else begin
                s_q <= core_sum;
                w_q <= core_cin;
            end
        end

        assign op_a   = a_q;
        assign op_b   = b_q;
        assign sum_o  = s_q;
        assign wrap_o = w_q;
    end else begin : g_comb
        assign op_a   = a_i;
        assign op_b   = b_i;
        assign sum_o  = core_sum;
        assign wrap_o = core_cin;
    end

    iwa_bitgen #(.N(N)) u_bitgen (
        .a_i (op_a),
        .b_i (op_b),
        .g_o (g_w),
        .p_o (p_w),
        .h_o (h_w)
    );

    iwa_anchor #(.N(N), .K(K)) u_anchor (
        .clk   (clk),
        .rst_n (rst_n),
        .g_i   (g_w),
        .p_i   (p_w),
        .anc_o (anc_w)
    );

    iwa_fill #(.N(N), .K(K)) u_fill (
        .clk    (clk),
        .rst_n  (rst_n),
        .g_i    (g_w),
        .p_i    (p_w),
        .h_i    (h_w),
        .anc_i  (anc_w),
        .sum_o  (core_sum),
        .wrap_o (core_cin)
    );

    // wide arithmetic sum, used only by the checks below
    assign ext_sum = {1'b0, op_a} + {1'b0, op_b};

    // result is the operand sum plus the wrap carry, modulo 2^N
    p_sum_mod_r1: assert property (@(posedge clk) disable iff (!rst_n)
        core_sum == N'(op_a + op_b + N'(core_cin)))
        else $error("sum does not match operands plus wrap carry");

    // wrap carry is set exactly when the plain addition does not overflow
    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        core_cin == !ext_sum[N])
        else $error("wrap carry does not invert the carry out");

endmodule

// File: tb/inv_wrap_adder_bench.sv
module inv_wrap_adder_bench;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [7:0] a;
        logic [7:0] b;
        logic [7:0] sum;
        logic       wrap;
        string      tag;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] a8 = '0, b8 = '0;
    logic [7:0] s8;
    logic w8;
    logic drv_vld = 1'b0;
    logic [1:0] vld_sr = 2'b00;
    item_t sb[$];

    logic [15:0] a16 = '0, b16 = '0;
    logic [15:0] s16 [4];
    logic        w16 [4];

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    inv_wrap_adder #(.N(8), .K(4), .REG_IO(1)) u_inv_wrap_adder (
        .clk (clk), .rst_n (rst_n), .a_i (a8), .b_i (b8),
        .sum_o (s8), .wrap_o (w8)
    );

    for (genvar i = 0; i < 4; i++) begin : g_w16
        localparam int KV = (i == 0) ? 1 : (i == 1) ? 4 : (i == 2) ? 8 : 16;
        inv_wrap_adder #(.N(16), .K(KV), .REG_IO(0)) u_w16 (
            .clk (clk), .rst_n (rst_n), .a_i (a16), .b_i (b16),
            .sum_o (s16[i]), .wrap_o (w16[i])
        );
    end

    // reference: wrap = no carry out; sum = (a + b + wrap) mod 2^w
    function automatic logic [16:0] model(input logic [15:0] a, input logic [15:0] b, input int w);
        logic [16:0] tot;
        logic [16:0] mask;
        logic        cin;
        tot  = {1'b0, a} + {1'b0, b};
        mask = (17'd1 << w) - 17'd1;
        cin  = ~tot[w];
        return {cin, 16'((tot + 17'(cin)) & mask)};
    endfunction

    function automatic string tag_for(input logic [15:0] a, input logic [15:0] b, input int w);
        logic [16:0] tot;
        logic [16:0] full;
        tot  = {1'b0, a} + {1'b0, b};
        full = 17'd1 << w;
        if (a == 16'(full - 1) && b == 16'(full - 1)) return "R4";
        if (a == 0 && b == 0) return "R5";
        if (tot == full - 1) return "R3";
        if (tot == full) return "R6";
        return "R1";
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // driver: presents one 8-bit pair and queues its expected result
    task automatic drive8(input logic [7:0] a, input logic [7:0] b);
        item_t it;
        logic [16:0] e;
        @(negedge clk);
        a8 = a;
        b8 = b;
        drv_vld = 1'b1;
        e = model({8'h0, a}, {8'h0, b}, 8);
        it.a = a;
        it.b = b;
        it.sum = e[7:0];
        it.wrap = e[16];
        it.tag = tag_for({8'h0, a}, {8'h0, b}, 8);
        sb.push_back(it);
    endtask

    // valid marker follows the two register stages
    always @(posedge clk) vld_sr <= {vld_sr[0], drv_vld};

    // monitor: pops the scoreboard as results leave the output register (R8)
    always @(negedge clk) begin
        if (vld_sr[1]) begin
            if (sb.size() == 0) begin
                check("R8", "unexpected result", 1, 0);
            end else begin
                item_t it;
                it = sb.pop_front();
                check(it.tag, $sformatf("sum8 %0h+%0h", it.a, it.b), s8, it.sum);
                check(it.tag == "R1" ? "R2" : it.tag,
                      $sformatf("wrap8 %0h+%0h", it.a, it.b), w8, it.wrap);
            end
        end
    end

    // 16-bit combinational variants against the model and each other (R7)
    task automatic drive16(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] e;
        string t;
        @(negedge clk);
        a16 = a;
        b16 = b;
        #1;
        e = model(a, b, 16);
        t = tag_for(a, b, 16);
        for (int i = 0; i < 4; i++) begin
            check(t, $sformatf("sum16[%0d] %0h+%0h", i, a, b), s16[i], e[15:0]);
            check(t == "R1" ? "R2" : t, $sformatf("wrap16[%0d]", i), w16[i], e[16]);
            if (i > 0) check("R7", $sformatf("K variant %0d vs 0", i),
                             {w16[i], s16[i]}, {w16[0], s16[0]});
        end
    endtask

    initial begin
        a8 = 8'hff;
        b8 = 8'h01;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8", "reset sum", s8, 0);
        check("R8", "reset wrap", w8, 0);
        rst_n = 1'b1;

        for (int x = 0; x < 256; x++)
            for (int y = 0; y < 256; y++)
                drive8(8'(x), 8'(y));
        @(negedge clk);
        drv_vld = 1'b0;
        repeat (4) @(negedge clk);
        check("R8", "scoreboard drained", sb.size(), 0);

        drive16(16'h0000, 16'h0000);   // R5
        drive16(16'hffff, 16'hffff);   // R4
        drive16(16'h00ff, 16'hff00);   // R3
        drive16(16'h1234, 16'hedcb);   // R3
        drive16(16'hffff, 16'h0000);   // R3
        drive16(16'h8000, 16'h8000);   // R6
        drive16(16'h0001, 16'hffff);   // R6
        drive16(16'h0001, 16'h0000);   // R1
        for (int r = 0; r < 2000; r++)
            drive16(16'($urandom), 16'($urandom));

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // watchdog: a hung run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL R8 watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule